// File: doc/BRIEF.md
# Word-Wide Flash Program-Verify Sequencer

This block writes a stream of 16-bit words into a flash array built from two byte-wide devices placed side by side, so that the low and high bytes of each word sit in separate devices. Each word arrives with its address on a valid/ready input. The block asks for the programming supply and waits until that supply reports its high level. It then runs a fixed bus sequence for the word: a program set-up command, the data itself, a programming pulse time, a program-verify command, a settle time and a read-back.

The read-back is first compared as a whole 16-bit word. If the whole word matches, the block moves on. If it does not match, the two byte lanes are judged separately. A lane that now holds its byte is masked. From then on, FFh is driven in that lane for the set-up command, the data and the verify command, so only the other device is pulsed again. A lane that still fails advances its own pulse counter. When that counter reaches the limit, the word is abandoned and the lane's bit is set in a two-bit error flag.

When the input runs dry, the block writes the read-reset command to both devices and drops its request for the programming supply. The flag keeps its value until the next batch of words begins.

Top module: `flashpv_seq`

## Requirements
- R1: During and after reset, `vppEnable`, `inReady`, `flashWe` and `flashRe` are low and `errFlag` is 0. While `vppEnable` is low, no bus strobe and no `inReady` occurs.
- R2: Seeing `inValid` while idle raises `vppEnable` in the next cycle. `inReady` is not asserted before a cycle in which `vppHigh` was sampled high.
- R3: For each accepted word the bus carries, in order: a write of the set-up command (`PROG_CMD` in both bytes); a write of the data; `PULSE_CYC` cycles without strobes; a write of the verify command (`VFY_CMD` in both bytes); `SETTLE_CYC` cycles without strobes; a one-cycle `flashRe`; and one compare cycle. Read data is expected in the cycle after `flashRe`. `flashAddr` carries the word's address on every strobe.
- R4: If the read-back equals the whole intended word, the word is finished and no further pulse is sent for it.
- R5: A lane whose byte (bits 7:0 low, bits 15:8 high) matches after a mismatched word is masked. Every later set-up, data and verify write for that word drives FFh in that lane, so that lane receives no further program pulse.
- R6: Each lane counts its own failed compares. On the failed compare that reaches `MAX_PULSES`, the word is ended and `errFlag` bit 0 (low lane) or bit 1 (high lane) is set. The value is 1 for low only, 2 for high only and 3 for both.
- R7: `errFlag` bits only accumulate during a batch. The flag holds its value in idle and is cleared in the cycle that a new batch starts.
- R8: When `inValid` is low in the accept cycle, one write of `READ_CMD` in both bytes follows, and `vppEnable` falls in the next cycle.
- R9: `inReady` is high only in the accept cycle between words, and never together with a bus strobe. The lane counters and masks start cleared for each accepted word, so its first set-up uses the full command.
- R10: If one lane verifies and the other reaches its limit in the same compare cycle, both take effect. The first lane is masked, the flag bit of the second lane is set, and the word ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Word accepted this cycle when inValid is also high |
| inAddr | input | ADDR_W | Word address |
| inData | input | 16 | Word to program |
| vppHigh | input | 1 | Programming supply has reached its high level |
| vppEnable | output | 1 | Request for the programming supply |
| flashAddr | output | ADDR_W | Array address |
| flashWdata | output | 16 | Command or data written to the two devices |
| flashWe | output | 1 | One-cycle write strobe |
| flashRe | output | 1 | One-cycle read strobe |
| flashRdata | input | 16 | Read data, valid in the cycle after flashRe |
| errFlag | output | 2 | Lane overrun flag (bit 0 low, bit 1 high) |

## Verification
Lane masking and lane overrun can fall on the same compare cycle. The bench provokes this with a word whose low byte needs exactly `MAX_PULSES` pulses and whose high byte needs two more, so the fourth compare both verifies the low lane and exhausts the high lane. The outcome is judged cycle by cycle against a behavioural model of the bus sequence. It is also judged afterwards by the pulse counts the bench's flash model recorded: the low lane gets exactly its needed pulses, the high lane gets exactly the limit, and `errFlag` reads 2.

// File: rtl/flashpv_pkg.sv
package flashpv_pkg;

  localparam int LANES = 2;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [3:0] {
    S_IDLE, S_RAMP, S_FETCH, S_SETUP, S_DATA, S_PULSE,
    S_VERIFY, S_SETTLE, S_READ, S_CHECK, S_RDRST
  } seqState_t;

  typedef enum logic [1:0] {
    BUS_PROG, BUS_DATA, BUS_VFY, BUS_RDRST
  } busSel_t;

  typedef struct packed {
    logic    loadWord;
    logic    judge;
    logic    clrFlag;
    busSel_t busSel;
  } strobes_t;

endpackage

// File: rtl/flashpv_ctrl.sv
module flashpv_ctrl
  import flashpv_pkg::*;
#(
  parameter int PULSE_CYC  = 10,
  parameter int SETTLE_CYC = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     vppHigh,
  input  logic     wordOk,
  input  logic     overNow,
  output strobes_t stb,
  output logic     vppEnable,
  output logic     inReady,
  output logic     flashWe,
  output logic     flashRe
);

  localparam int LONGEST = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int TW = $clog2(LONGEST + 1);

  seqState_t state, nxt;
  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      timer <= '0;
    end else begin
      state <= nxt;
      timer <= (nxt != state) ? '0 : timer + TW'(1);
    end
  end

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (inValid) nxt = S_RAMP;
      S_RAMP:   if (vppHigh) nxt = S_FETCH;
      S_FETCH:  nxt = inValid ? S_SETUP : S_RDRST;
      S_SETUP:  nxt = S_DATA;
      S_DATA:   nxt = S_PULSE;
      S_PULSE:  if (timer == TW'(PULSE_CYC - 1)) nxt = S_VERIFY;
      S_VERIFY: nxt = S_SETTLE;
      S_SETTLE: if (timer == TW'(SETTLE_CYC - 1)) nxt = S_READ;
      S_READ:   nxt = S_CHECK;
      S_CHECK:  nxt = (wordOk || overNow) ? S_FETCH : S_SETUP;
      S_RDRST:  nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_comb begin
    vppEnable = (state != S_IDLE);
    inReady   = (state == S_FETCH);
    flashWe   = (state == S_SETUP) || (state == S_DATA) ||
                (state == S_VERIFY) || (state == S_RDRST);
    flashRe   = (state == S_READ);
    stb.loadWord = (state == S_FETCH) && inValid;
    stb.judge    = (state == S_CHECK);
    stb.clrFlag  = (state == S_IDLE) && inValid;
    unique case (state)
      S_DATA:   stb.busSel = BUS_DATA;
      S_VERIFY: stb.busSel = BUS_VFY;
      S_RDRST:  stb.busSel = BUS_RDRST;
      default:  stb.busSel = BUS_PROG;
    endcase
  end

endmodule

// File: rtl/flashpv_dpath.sv
module flashpv_dpath
  import flashpv_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          MAX_PULSES = 25,
  parameter logic [7:0]  PROG_CMD   = 8'h40,
  parameter logic [7:0]  VFY_CMD    = 8'hC0,
  parameter logic [7:0]  READ_CMD   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [WORD_W-1:0] inData,
  input  logic [WORD_W-1:0] flashRdata,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [WORD_W-1:0] flashWdata,
  output logic [LANES-1:0]  errFlag,
  output logic              wordOk,
  output logic              overNow
);

  localparam int CW = $clog2(MAX_PULSES + 1);

  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] dataReg;
  logic [LANES-1:0]  laneOk, laneOver, laneMask;
  logic [WORD_W-1:0] maskWord, rawWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg <= '0;
      dataReg <= '0;
    end else if (stb.loadWord) begin
      addrReg <= inAddr;
      dataReg <= inData;
    end
  end

  assign wordOk = (flashRdata == dataReg);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CW-1:0] cnt;
    logic          mask;
    assign laneOk[l]   = flashRdata[LANE_W*l +: LANE_W] == dataReg[LANE_W*l +: LANE_W];
    assign laneOver[l] = !laneOk[l] && (cnt == CW'(MAX_PULSES - 1));
    assign laneMask[l] = mask;
    assign maskWord[LANE_W*l +: LANE_W] = {LANE_W{mask}};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        mask <= 1'b0;
      end else if (stb.loadWord) begin
        cnt  <= '0;
        mask <= 1'b0;
      end else if (stb.judge && !wordOk) begin
        if (laneOk[l]) mask <= 1'b1;
        else           cnt  <= cnt + CW'(1);
      end
    end
  end

  assign overNow = |laneOver;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  errFlag <= '0;
    else if (stb.clrFlag)        errFlag <= '0;
    else if (stb.judge && !wordOk) errFlag <= errFlag | laneOver;
  end

  always_comb begin
    unique case (stb.busSel)
      BUS_DATA:  rawWord = dataReg;
      BUS_VFY:   rawWord = {LANES{VFY_CMD}};
      BUS_RDRST: rawWord = {LANES{READ_CMD}};
      default:   rawWord = {LANES{PROG_CMD}};
    endcase
    flashWdata = (stb.busSel == BUS_RDRST) ? rawWord : (rawWord | maskWord);
  end

  assign flashAddr = addrReg;

endmodule

// File: rtl/flashpv_seq.sv
module flashpv_seq
  import flashpv_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         MAX_PULSES = 25,
  parameter int         PULSE_CYC  = 10,
  parameter int         SETTLE_CYC = 6,
  parameter logic [7:0] PROG_CMD   = 8'h40,
  parameter logic [7:0] VFY_CMD    = 8'hC0,
  parameter logic [7:0] READ_CMD   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [15:0]       inData,
  input  logic              vppHigh,
  output logic              vppEnable,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [15:0]       flashWdata,
  output logic              flashWe,
  output logic              flashRe,
  input  logic [15:0]       flashRdata,
  output logic [1:0]        errFlag
);

  strobes_t stb;
  logic     wordOk, overNow;

  flashpv_ctrl #(.PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .vppHigh(vppHigh),
    .wordOk(wordOk), .overNow(overNow), .stb(stb), .vppEnable(vppEnable),
    .inReady(inReady), .flashWe(flashWe), .flashRe(flashRe)
  );

  flashpv_dpath #(
    .ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES),
    .PROG_CMD(PROG_CMD), .VFY_CMD(VFY_CMD), .READ_CMD(READ_CMD)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inAddr(inAddr), .inData(inData),
    .flashRdata(flashRdata), .flashAddr(flashAddr), .flashWdata(flashWdata),
    .errFlag(errFlag), .wordOk(wordOk), .overNow(overNow)
  );

endmodule

// File: rtl/flashpv_checker.sv
module flashpv_checker #(
  parameter logic [7:0] READ_CMD = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        inReady,
  input logic        vppEnable,
  input logic        flashWe,
  input logic        flashRe,
  input logic [15:0] flashWdata,
  input logic [1:0]  errFlag
);

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vppEnable |-> !(flashWe || flashRe || inReady));

  a_r2_ramp_before_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vppEnable) |-> !inReady);

  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    flashRe |=> !flashRe && !flashWe);

  a_r9_ready_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> !flashWe && !flashRe);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (vppEnable && $past(vppEnable)) |-> ((errFlag & $past(errFlag)) == $past(errFlag)));

  a_r8_off_after_rdrst: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vppEnable) |-> ($past(flashWe) && ($past(flashWdata) == {READ_CMD, READ_CMD})));

endmodule

bind flashpv_seq flashpv_checker #(.READ_CMD(READ_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .inReady(inReady), .vppEnable(vppEnable),
  .flashWe(flashWe), .flashRe(flashRe), .flashWdata(flashWdata), .errFlag(errFlag)
);

// File: tb/flashpv_seq_test.sv
module flashpv_seq_test;

  localparam int AW = 4;
  localparam int MAXP = 4;
  localparam int PCYC = 3;
  localparam int SCYC = 2;
  localparam logic [7:0] PC = 8'h40;
  localparam logic [7:0] VC = 8'hC0;
  localparam logic [7:0] RC = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [AW-1:0] inAddr = '0;
  logic [15:0] inData = '0;
  logic vppHigh = 1'b0;
  logic vppEnable;
  logic [AW-1:0] flashAddr;
  logic [15:0] flashWdata;
  logic flashWe, flashRe;
  logic [15:0] flashRdata = 16'hFFFF;
  logic [1:0] errFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit modelOn = 0;

  always #2 clk = ~clk;

  flashpv_seq #(
    .ADDR_W(AW), .MAX_PULSES(MAXP), .PULSE_CYC(PCYC), .SETTLE_CYC(SCYC),
    .PROG_CMD(PC), .VFY_CMD(VC), .READ_CMD(RC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .inData(inData), .vppHigh(vppHigh), .vppEnable(vppEnable),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashWe(flashWe),
    .flashRe(flashRe), .flashRdata(flashRdata), .errFlag(errFlag)
  );

  // flash pair model: a lane is pulsed by a write that follows a set-up byte
  logic [15:0] mem [16];
  int need [16][2];
  int pulses [16][2];
  logic [1:0] armed = 2'b00;

  always @(posedge clk) begin
    if (flashRe) flashRdata <= mem[flashAddr];
    if (flashWe) begin
      for (int l = 0; l < 2; l++) begin
        if (armed[l]) begin
          pulses[flashAddr][l] = pulses[flashAddr][l] + 1;
          if (pulses[flashAddr][l] >= need[flashAddr][l])
            mem[flashAddr][8*l +: 8] <= flashWdata[8*l +: 8];
          armed[l] <= 1'b0;
        end else begin
          armed[l] <= (flashWdata[8*l +: 8] == PC);
        end
      end
    end
  end

  // supply ramp: high three cycles after the request
  int rampCnt = 0;
  always @(posedge clk) begin
    if (!vppEnable) begin
      rampCnt <= 0;
      vppHigh <= 1'b0;
    end else if (rampCnt == 3) vppHigh <= 1'b1;
    else rampCnt <= rampCnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // behavioural reference of the bus sequence
  logic expWe = 0, expRe = 0, expVpp = 0, expRdy = 0;
  logic [15:0] expWd = '0;
  logic [AW-1:0] expAddr = '0;
  logic [1:0] expFlag = 2'b00;

  task automatic cyc(input logic we, input logic re, input logic [15:0] wd, input logic vpp, input logic rdy);
    expWe = we; expRe = re; expWd = wd; expVpp = vpp; expRdy = rdy;
    @(posedge clk);
  endtask

  initial begin : model
    logic [15:0] d, rd, mw;
    int cnt [2];
    bit msk [2];
    bit ovr;
    wait (rst_n);
    modelOn = 1;
    forever begin
      cyc(0, 0, 16'h0, 0, 0);
      if (inValid) begin
        expFlag = 2'b00;
        do cyc(0, 0, 16'h0, 1, 0); while (!vppHigh);
        forever begin
          cyc(0, 0, 16'h0, 1, 1);
          if (!inValid) begin
            cyc(1, 0, {RC, RC}, 1, 0);
            break;
          end
          expAddr = inAddr;
          d = inData;
          for (int l = 0; l < 2; l++) begin cnt[l] = 0; msk[l] = 0; end
          forever begin
            mw = {{8{msk[1]}}, {8{msk[0]}}};
            cyc(1, 0, {PC, PC} | mw, 1, 0);
            cyc(1, 0, d | mw, 1, 0);
            repeat (PCYC) cyc(0, 0, 16'h0, 1, 0);
            cyc(1, 0, {VC, VC} | mw, 1, 0);
            repeat (SCYC) cyc(0, 0, 16'h0, 1, 0);
            cyc(0, 1, 16'h0, 1, 0);
            cyc(0, 0, 16'h0, 1, 0);
            rd = flashRdata;
            if (rd == d) break;
            ovr = 0;
            for (int l = 0; l < 2; l++) begin
              if (rd[8*l +: 8] == d[8*l +: 8]) msk[l] = 1;
              else begin
                cnt[l]++;
                if (cnt[l] == MAXP) begin ovr = 1; expFlag[l] = 1'b1; end
              end
            end
            if (ovr) break;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      chk(vppEnable == expVpp, "R2/R8 vppEnable", 32'(vppEnable), 32'(expVpp));
      chk(inReady == expRdy, "R9 inReady", 32'(inReady), 32'(expRdy));
      chk(flashWe == expWe, "R3 flashWe", 32'(flashWe), 32'(expWe));
      chk(flashRe == expRe, "R3 flashRe", 32'(flashRe), 32'(expRe));
      chk(errFlag == expFlag, "R6/R7 errFlag", 32'(errFlag), 32'(expFlag));
      if (expWe) chk(flashWdata == expWd, "R5 flashWdata", 32'(flashWdata), 32'(expWd));
      if (expWe || expRe) chk(flashAddr == expAddr, "R3 flashAddr", 32'(flashAddr), 32'(expAddr));
    end
  end

  task automatic setNeed(input int a, input int lo, input int hi);
    need[a][0] = lo;
    need[a][1] = hi;
  endtask

  task automatic sendWord(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    inValid = 1'b1; inAddr = a; inData = d;
    @(posedge clk);
    while (!inReady) @(posedge clk);
  endtask

  task automatic endBatch();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    while (vppEnable) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic lanePulses(input int a, input int lo, input int hi, input string tag);
    chk(pulses[a][0] == lo, tag, 32'(pulses[a][0]), 32'(lo));
    chk(pulses[a][1] == hi, tag, 32'(pulses[a][1]), 32'(hi));
  endtask

  initial begin : driver
    for (int a = 0; a < 16; a++) begin
      mem[a] = 16'hFFFF;
      for (int l = 0; l < 2; l++) begin need[a][l] = 1; pulses[a][l] = 0; end
    end
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!vppEnable && !inReady && !flashWe && !flashRe, "R1 strobes in reset",
        {vppEnable, inReady, flashWe, flashRe}, 32'h0);
    chk(errFlag == 2'b00, "R1 flag in reset", 32'(errFlag), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!vppEnable && !inReady, "R1 idle after reset", {vppEnable, inReady}, 32'h0);

    // batch 1
    setNeed(1, 1, 1);
    setNeed(2, 3, 1);
    setNeed(3, 1, 4);
    setNeed(4, 4, 6);
    setNeed(5, 1, 2);
    sendWord(4'd1, 16'h1234);
    sendWord(4'd2, 16'hA55A);
    sendWord(4'd3, 16'h0F0F);
    sendWord(4'd4, 16'h3CC3);
    sendWord(4'd5, 16'h7E81);
    endBatch();
    chk(mem[1] == 16'h1234, "R4 first-try word stored", 32'(mem[1]), 32'h1234);
    lanePulses(1, 1, 1, "R4 one pulse per lane");
    chk(mem[2] == 16'hA55A, "R5 word with masked high lane", 32'(mem[2]), 32'hA55A);
    lanePulses(2, 3, 1, "R5 masked lane not pulsed again");
    chk(mem[3] == 16'h0F0F, "R6 lane verifying at the limit", 32'(mem[3]), 32'h0F0F);
    lanePulses(3, 1, 4, "R6 limit pulses allowed");
    lanePulses(4, 4, MAXP, "R10 verify and overrun together");
    chk(mem[4] == 16'hFFC3, "R10 low stored high unprogrammed", 32'(mem[4]), 32'hFFC3);
    lanePulses(5, 1, 2, "R9 counters cleared for next word");
    chk(errFlag == 2'b10, "R10 flag high lane only", 32'(errFlag), 32'h2);

    // batch 2: clean word, flag must restart from 0
    setNeed(7, 1, 1);
    sendWord(4'd7, 16'h1111);
    endBatch();
    chk(errFlag == 2'b00, "R7 flag cleared at new batch", 32'(errFlag), 32'h0);
    chk(mem[7] == 16'h1111, "R4 batch 2 word", 32'(mem[7]), 32'h1111);

    // batch 3: both lanes exhaust together
    setNeed(6, 9, 9);
    sendWord(4'd6, 16'h5AA5);
    endBatch();
    chk(errFlag == 2'b11, "R6 both lanes overrun", 32'(errFlag), 32'h3);
    lanePulses(6, MAXP, MAXP, "R6 pulses stop at limit");
    chk(!vppEnable && !inReady, "R8 supply released", {vppEnable, inReady}, 32'h0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin : watchdog
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R3 sequence hung actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule